// File: doc/BRIEF.md
# Backward Fault Signal Controller

This block holds the backward fault state of one 2x2 switching element in a multistage cell switch. Each element has two input controllers that share one spare input controller, and two output controllers, each with a spare of its own. A half of the element (upper or lower) is declared failed only when a normal controller and the spare that backs it have both failed. A failure reported by the downstream element on that half is passed straight through. The two resulting flags are registered and sent upstream, one stage per clock.

At the front of the network the same element also builds the extended routing tag for each arriving cell. It puts one extra leading bit in front of the destination address. A 0 sends the cell along the normal path, and a 1 sends it along the disjoint alternate path. The leading bit is taken from the registered upper fault flag, because the normal path leaves the front stage through its upper half. This bit is sampled once, on the cycle the cell starts, and then held. A sticky mode keeps a reported fault latched until reset, for systems that treat a failure as permanent.

Top module: `bfc_ctrl`

## Requirements
- R1: While reset is active and right after it is released, `flt_up`, `flt_lo`, `tag_vld` and `route_tag` are all 0.
- R2: If `dn_flt_up` is 1 at a clock edge, `flt_up` is 1 after that edge.
- R3: If `dn_flt_lo` is 1 at a clock edge, `flt_lo` is 1 after that edge.
- R4: `flt_up` is 1 after an edge at which `ic_flt[0]` and `spare_ic_flt` are both 1, or `oc_flt[0]` and `spare_oc_flt[0]` are both 1. Bit 0 is controller 1, the upper half.
- R5: `flt_lo` is 1 after an edge at which `ic_flt[1]` and `spare_ic_flt` are both 1, or `oc_flt[1]` and `spare_oc_flt[1]` are both 1. Bit 1 is controller 2, the lower half.
- R6: A single faulty controller whose backing spare is healthy leaves the fault flag of its half at 0.
- R7: With `sticky_en` at 0, a fault flag returns to 0 one clock after every condition that raised it has cleared.
- R8: With `sticky_en` at 1, a fault flag that is 1 stays 1 until reset.
- R9: One clock after `cell_start` is 1, `tag_vld` is 1 and `route_tag` equals {leading bit, `dest_addr`}. The leading bit is the `flt_up` value just before that edge: 0 selects the normal path and 1 the alternate path. `tag_vld` is 0 one clock after a cycle without `cell_start`.
- R10: `route_tag` changes only on a cycle that follows `cell_start`, so a fault change in the middle of a cell does not move that cell onto the other path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ic_flt | input | 2 | Input controller fault flags, bit 0 upper, bit 1 lower |
| spare_ic_flt | input | 1 | Shared spare input controller fault flag |
| oc_flt | input | 2 | Output controller fault flags, bit 0 upper, bit 1 lower |
| spare_oc_flt | input | 2 | Spare output controller fault flags, bit 0 upper, bit 1 lower |
| dn_flt_up | input | 1 | Upper fault signal from the downstream element |
| dn_flt_lo | input | 1 | Lower fault signal from the downstream element |
| sticky_en | input | 1 | Latch reported faults until reset |
| cell_start | input | 1 | First cycle of a cell at the network edge |
| dest_addr | input | log2(NUM_PORTS) | Destination output port of the starting cell |
| flt_up | output | 1 | Registered upper backward fault signal |
| flt_lo | output | 1 | Registered lower backward fault signal |
| tag_vld | output | 1 | Routing tag valid, one clock after cell start |
| route_tag | output | log2(NUM_PORTS)+1 | Path-select bit followed by the destination address |

## Verification
The properties assume that every input is a clean, synchronous level that is valid at each rising edge. They also assume that `cell_start` and `dest_addr` are presented together for a single cycle. The stimulus changes every input only on falling edges and keeps reset inactive between the phases it drives. It raises `cell_start` in isolated cycles as well as in back-to-back runs, which covers tag sampling both with and without a gap between cells.

// File: rtl/bfc_pkg.sv
package bfc_pkg;

    // Backward fault state of one element: one flag per half.
    typedef struct packed {
        logic up;
        logic lo;
    } bfc_flt_t;

    // Index of each half inside the per-half input vectors.
    localparam int SIDE_UP = 0;
    localparam int SIDE_LO = 1;
    localparam int NUM_SIDES = 2;

endpackage

// File: rtl/bfc_side_eval.sv
// Failure decision for one half of the element: a normal controller
// only takes the half down when its spare has failed too; a failure
// reported from downstream always takes it down.
module bfc_side_eval (
    input  logic ctl_in_bad,
    input  logic spare_in_bad,
    input  logic ctl_out_bad,
    input  logic spare_out_bad,
    input  logic dn_bad,
    output logic side_fail
);

    logic in_lost;
    logic out_lost;

    always_comb begin
        in_lost   = ctl_in_bad  & spare_in_bad;
        out_lost  = ctl_out_bad & spare_out_bad;
        side_fail = dn_bad | in_lost | out_lost;
    end

endmodule

// File: rtl/bfc_tag_gen.sv
// Edge-of-network tag builder: captures the path-select bit and the
// destination once per cell and holds them until the next cell.
module bfc_tag_gen #(
    parameter int ADDR_W = 4,
    localparam int TAG_W = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cell_start,
    input  logic [ADDR_W-1:0] dest_addr,
    input  logic              alt_path,
    output logic              tag_vld,
    output logic [TAG_W-1:0]  route_tag
);

    typedef struct packed {
        logic             vld;
        logic [TAG_W-1:0] tag;
    } tag_state_t;

    tag_state_t ts_d;
    tag_state_t ts_q;

    always_comb begin
        ts_d     = ts_q;
        ts_d.vld = cell_start;
        if (cell_start) begin
            ts_d.tag = {alt_path, dest_addr};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ts_q <= '0;
        end else begin
            ts_q <= ts_d;
        end
    end

    assign tag_vld   = ts_q.vld;
    assign route_tag = ts_q.tag;

endmodule

// File: rtl/bfc_ctrl.sv
module bfc_ctrl
    import bfc_pkg::*;
#(
    parameter int NUM_PORTS = 16,
    parameter bit EDGE_EN   = 1'b1,
    localparam int ADDR_W   = $clog2(NUM_PORTS),
    localparam int TAG_W    = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        ic_flt,
    input  logic              spare_ic_flt,
    input  logic [1:0]        oc_flt,
    input  logic [1:0]        spare_oc_flt,
    input  logic              dn_flt_up,
    input  logic              dn_flt_lo,
    input  logic              sticky_en,
    input  logic              cell_start,
    input  logic [ADDR_W-1:0] dest_addr,
    output logic              flt_up,
    output logic              flt_lo,
    output logic              tag_vld,
    output logic [TAG_W-1:0]  route_tag
);

    logic [NUM_SIDES-1:0] dn_vec;
    logic [NUM_SIDES-1:0] side_fail;

    assign dn_vec[SIDE_UP] = dn_flt_up;
    assign dn_vec[SIDE_LO] = dn_flt_lo;

    // One evaluator per half; both share the single spare input controller.
    for (genvar g = 0; g < NUM_SIDES; g++) begin : g_side
        bfc_side_eval u_eval (
            .ctl_in_bad   (ic_flt[g]),
            .spare_in_bad (spare_ic_flt),
            .ctl_out_bad  (oc_flt[g]),
            .spare_out_bad(spare_oc_flt[g]),
            .dn_bad       (dn_vec[g]),
            .side_fail    (side_fail[g])
        );
    end

    bfc_flt_t st_d;
    bfc_flt_t st_q;

    always_comb begin
        st_d.up = side_fail[SIDE_UP] | (sticky_en & st_q.up);
        st_d.lo = side_fail[SIDE_LO] | (sticky_en & st_q.lo);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flt_up = st_q.up;
    assign flt_lo = st_q.lo;

    // The normal path leaves the front stage through the upper half.
    if (EDGE_EN) begin : g_edge
        bfc_tag_gen #(.ADDR_W(ADDR_W)) u_tag (
            .clk       (clk),
            .rst_n     (rst_n),
            .cell_start(cell_start),
            .dest_addr (dest_addr),
            .alt_path  (st_q.up),
            .tag_vld   (tag_vld),
            .route_tag (route_tag)
        );
    end else begin : g_inner
        assign tag_vld   = 1'b0;
        assign route_tag = '0;
    end

endmodule

// File: rtl/bfc_ctrl_chk.sv
module bfc_ctrl_chk #(
    parameter int ADDR_W  = 4,
    parameter bit EDGE_EN = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        ic_flt,
    input logic              spare_ic_flt,
    input logic [1:0]        oc_flt,
    input logic [1:0]        spare_oc_flt,
    input logic              dn_flt_up,
    input logic              dn_flt_lo,
    input logic              sticky_en,
    input logic              cell_start,
    input logic [ADDR_W-1:0] dest_addr,
    input logic              flt_up,
    input logic              flt_lo,
    input logic              tag_vld,
    input logic [ADDR_W:0]   route_tag
);

    assert_dn_up_fwd_R2: assert property (@(posedge clk) disable iff (!rst_n)
        dn_flt_up |=> flt_up);

    assert_dn_lo_fwd_R3: assert property (@(posedge clk) disable iff (!rst_n)
        dn_flt_lo |=> flt_lo);

    assert_up_pair_lost_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((ic_flt[0] && spare_ic_flt) || (oc_flt[0] && spare_oc_flt[0])) |=> flt_up);

    assert_lo_pair_lost_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((ic_flt[1] && spare_ic_flt) || (oc_flt[1] && spare_oc_flt[1])) |=> flt_lo);

    assert_up_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!sticky_en && !dn_flt_up && !(ic_flt[0] && spare_ic_flt)
         && !(oc_flt[0] && spare_oc_flt[0])) |=> !flt_up);

    assert_lo_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!sticky_en && !dn_flt_lo && !(ic_flt[1] && spare_ic_flt)
         && !(oc_flt[1] && spare_oc_flt[1])) |=> !flt_lo);

    assert_up_latched_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sticky_en && flt_up) |=> flt_up);

    assert_lo_latched_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sticky_en && flt_lo) |=> flt_lo);

    if (EDGE_EN) begin : g_edge_chk
        assert_tag_built_R9: assert property (@(posedge clk) disable iff (!rst_n)
            cell_start |=> (tag_vld && route_tag == {$past(flt_up), $past(dest_addr)}));

        assert_tag_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
            !cell_start |=> !tag_vld);

        assert_tag_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
            !cell_start |=> $stable(route_tag));
    end

endmodule

bind bfc_ctrl bfc_ctrl_chk #(.ADDR_W(ADDR_W), .EDGE_EN(EDGE_EN)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ic_flt      (ic_flt),
    .spare_ic_flt(spare_ic_flt),
    .oc_flt      (oc_flt),
    .spare_oc_flt(spare_oc_flt),
    .dn_flt_up   (dn_flt_up),
    .dn_flt_lo   (dn_flt_lo),
    .sticky_en   (sticky_en),
    .cell_start  (cell_start),
    .dest_addr   (dest_addr),
    .flt_up      (flt_up),
    .flt_lo      (flt_lo),
    .tag_vld     (tag_vld),
    .route_tag   (route_tag)
);

// File: tb/sim_bfc_ctrl.sv
module sim_bfc_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int NPORTS     = 16;
    localparam int AW         = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    ic_flt = '0;
    logic          spare_ic_flt = 1'b0;
    logic [1:0]    oc_flt = '0;
    logic [1:0]    spare_oc_flt = '0;
    logic          dn_flt_up = 1'b0;
    logic          dn_flt_lo = 1'b0;
    logic          sticky_en = 1'b0;
    logic          cell_start = 1'b0;
    logic [AW-1:0] dest_addr = '0;
    logic          flt_up;
    logic          flt_lo;
    logic          tag_vld;
    logic [AW:0]   route_tag;

    int total = 0;
    int bad   = 0;

    typedef struct {
        logic        up;
        logic        lo;
        logic        vld;
        logic [AW:0] tag;
        string       req;
    } exp_t;

    exp_t exp_q[$];

    // Reference state, independent of the design.
    logic        m_up = 1'b0;
    logic        m_lo = 1'b0;
    logic [AW:0] m_tag = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bfc_ctrl #(.NUM_PORTS(NPORTS), .EDGE_EN(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .ic_flt(ic_flt), .spare_ic_flt(spare_ic_flt),
        .oc_flt(oc_flt), .spare_oc_flt(spare_oc_flt), .dn_flt_up(dn_flt_up),
        .dn_flt_lo(dn_flt_lo), .sticky_en(sticky_en), .cell_start(cell_start),
        .dest_addr(dest_addr), .flt_up(flt_up), .flt_lo(flt_lo),
        .tag_vld(tag_vld), .route_tag(route_tag)
    );

    // Driver: drives one cycle of stimulus on the falling edge and pushes the
    // values expected after the next rising edge.
    task automatic step(input logic [1:0] ic, input logic sic, input logic [1:0] oc,
                        input logic [1:0] soc, input logic du, input logic dl,
                        input logic stk, input logic st, input logic [AW-1:0] da,
                        input string req);
        exp_t e;
        logic nu;
        logic nl;
        @(negedge clk);
        ic_flt = ic; spare_ic_flt = sic; oc_flt = oc; spare_oc_flt = soc;
        dn_flt_up = du; dn_flt_lo = dl; sticky_en = stk;
        cell_start = st; dest_addr = da;
        nu = du | (ic[0] & sic) | (oc[0] & soc[0]) | (stk & m_up);
        nl = dl | (ic[1] & sic) | (oc[1] & soc[1]) | (stk & m_lo);
        if (st) m_tag = {m_up, da};
        m_up = nu;
        m_lo = nl;
        e.up = m_up; e.lo = m_lo; e.vld = st; e.tag = m_tag; e.req = req;
        exp_q.push_back(e);
    endtask

    task automatic idle(input string req);
        step(2'b00, 1'b0, 2'b00, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, '0, req);
    endtask

    // Monitor: compares a quarter period after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #(CLK_PERIOD/4);
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                total++;
                if (flt_up !== e.up || flt_lo !== e.lo || tag_vld !== e.vld
                    || route_tag !== e.tag) begin
                    bad++;
                    $display("FAIL %s: up/lo/vld/tag actual=%b%b%b %b expected=%b%b%b %b",
                             e.req, flt_up, flt_lo, tag_vld, route_tag,
                             e.up, e.lo, e.vld, e.tag);
                end
            end
        end
    end

    task automatic check_reset_state(input string req);
        total++;
        if (flt_up !== 1'b0 || flt_lo !== 1'b0 || tag_vld !== 1'b0 || route_tag !== '0) begin
            bad++;
            $display("FAIL %s: up/lo/vld/tag actual=%b%b%b %b expected=000 00000",
                     req, flt_up, flt_lo, tag_vld, route_tag);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        @(negedge clk);
        ic_flt = '0; spare_ic_flt = 0; oc_flt = '0; spare_oc_flt = '0;
        dn_flt_up = 0; dn_flt_lo = 0; sticky_en = 0; cell_start = 0; dest_addr = '0;
        rst_n = 1'b0;
        m_up = 0; m_lo = 0; m_tag = '0;
        #(CLK_PERIOD/4);
        check_reset_state("R1 during reset");
        @(negedge clk);
        rst_n = 1'b1;
        #(CLK_PERIOD/4);
        check_reset_state("R1 after release");
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        do_reset();
        idle("R1 idle");
        // Downstream forwarding and clearing
        step(2'b00, 0, 2'b00, 2'b00, 1, 0, 0, 0, '0, "R2 dn upper");
        idle("R7 upper clears");
        step(2'b00, 0, 2'b00, 2'b00, 0, 1, 0, 0, '0, "R3 dn lower");
        idle("R7 lower clears");
        // Local pairs
        step(2'b01, 1, 2'b00, 2'b00, 0, 0, 0, 0, '0, "R4 ic1+spare ic");
        step(2'b00, 0, 2'b01, 2'b01, 0, 0, 0, 0, '0, "R4 oc1+spare oc1");
        step(2'b10, 1, 2'b00, 2'b00, 0, 0, 0, 0, '0, "R5 ic2+spare ic");
        step(2'b00, 0, 2'b10, 2'b10, 0, 0, 0, 0, '0, "R5 oc2+spare oc2");
        step(2'b11, 1, 2'b00, 2'b00, 0, 0, 0, 0, '0, "R4 R5 both ic+spare");
        // Single faults with spare healthy
        step(2'b01, 0, 2'b00, 2'b00, 0, 0, 0, 0, '0, "R6 ic1 alone");
        step(2'b00, 1, 2'b00, 2'b00, 0, 0, 0, 0, '0, "R6 spare ic alone");
        step(2'b00, 0, 2'b11, 2'b00, 0, 0, 0, 0, '0, "R6 both oc alone");
        step(2'b00, 0, 2'b00, 2'b11, 0, 0, 0, 0, '0, "R6 spare oc alone");
        step(2'b00, 0, 2'b01, 2'b10, 0, 0, 0, 0, '0, "R6 crossed oc/spare");
        // Sticky latching
        step(2'b00, 0, 2'b00, 2'b00, 1, 0, 1, 0, '0, "R8 set upper");
        step(2'b00, 0, 2'b00, 2'b00, 0, 0, 1, 0, '0, "R8 upper held");
        step(2'b00, 0, 2'b10, 2'b10, 0, 0, 1, 0, '0, "R8 set lower");
        for (int i = 0; i < 4; i++) step(2'b00, 0, 2'b00, 2'b00, 0, 0, 1, 0, '0, "R8 both held");
        do_reset();
        // Tag generation
        step(2'b00, 0, 2'b00, 2'b00, 0, 0, 0, 1, 4'd10, "R9 normal path tag");
        step(2'b00, 0, 2'b00, 2'b00, 1, 0, 0, 1, 4'd3, "R9 start with new fault");
        step(2'b00, 0, 2'b00, 2'b00, 0, 0, 0, 1, 4'd10, "R9 alternate path tag");
        step(2'b00, 0, 2'b00, 2'b00, 1, 0, 0, 0, '0, "R10 held during cell");
        step(2'b00, 0, 2'b00, 2'b00, 0, 1, 0, 0, 4'd7, "R10 held fault changes");
        idle("R10 held idle");
        step(2'b00, 0, 2'b00, 2'b00, 0, 0, 0, 1, 4'd15, "R9 top address");
        step(2'b00, 0, 2'b00, 2'b00, 0, 0, 0, 1, 4'd0, "R9 zero address");
        // Mixed stimulus
        for (int i = 0; i < 300; i++) begin
            logic [15:0] r;
            r = 16'($urandom);
            step(r[1:0], r[2], r[4:3], r[6:5], r[7] & r[8], r[9] & r[10],
                 r[11] & r[12] & r[13], r[14], {r[15], r[2], r[9], r[0]}, "R2 R4 R5 R9 mixed");
        end
        idle("R7 final");
        repeat (3) @(posedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule